// File: doc/BRIEF.md
# Nine-bit UART transmitter

This block sends one asynchronous serial frame of eleven bit periods on a single output line. Software writes a byte and, at the same moment, presents a ninth bit. The block then sends a low start bit, the eight byte bits with the least significant bit first, the ninth bit, and a high stop bit. The line idles high.

Bit timing comes from a slice counter of 16 states. The counter runs freely from reset and advances once per baud tick. A prescaler divides an oscillator-rate enable by 2 or by 4 to make the baud tick, so one bit lasts 32 or 64 oscillator periods, chosen by a rate-select input. A write does not start the frame at once. It arms the transmitter, and the start bit goes out at the next wrap of the slice counter. Every later bit goes out at a later wrap. Frames therefore sit on a fixed grid that the write does not move.

A sticky done flag rises at the same wrap that drives the stop bit, which is the eleventh wrap after the write. It stays high until software pulses a clear input. A write that arrives while a frame is armed or running is dropped.

Top module: `uart9_tx`

## Requirements
- R1: After reset the serial output `txd` is 1 and `done_flag` is 0.
- R2: A frame on `txd` is, in this order: a 0 start bit, then `wr_data[0]` through `wr_data[7]`, then the `ninth_bit` value, then a 1 stop bit. The data and the ninth bit are captured in the cycle of the accepted write.
- R3: Every bit lasts 32 `osc_en` pulses when `fast_rate` is 1 and 64 `osc_en` pulses when `fast_rate` is 0. With `osc_en` held high this is 32 or 64 clock cycles.
- R4: `txd` changes only at a wrap of the free-running slice counter. The start bit appears at the first wrap after the write, so it comes between 1 and one bit period of cycles after the write, and the start times of different frames differ by a whole number of bit periods.
- R5: `done_flag` rises in the same cycle that the stop bit is first driven, which is 10 bit periods after the start edge.
- R6: Once set, `done_flag` stays 1 until a cycle with `clr_done` high. It reads 0 from the next cycle on.
- R7: A write is ignored from the accepted write until `done_flag` rises. It changes neither the frame in flight nor anything afterwards, and no second frame follows.
- R8: With no accepted write pending, `txd` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle pulse per oscillator period |
| fast_rate | input | 1 | 1: bit = 32 oscillator periods; 0: bit = 64 |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | 8 | Byte to send |
| ninth_bit | input | 1 | Ninth bit, sampled together with the byte |
| clr_done | input | 1 | Clears the done flag |
| txd | output | 1 | Serial output, idle high |
| done_flag | output | 1 | Transmit-done flag |

## Verification
On every cycle the assertions check the following:
- `txd` moves only at a slice-counter wrap.
- The done flag rises only while the stop level is on the line.
- The done flag holds until it is cleared, and a clear takes effect in the next cycle.
- A write arriving mid-frame leaves the frame shift register untouched.

Only the bench scenarios can show the frame as a whole:
- the exact bit order and values;
- the 32- and 64-period bit lengths, including with a gapped oscillator enable;
- the one-bit-period window between a write and its start bit, and the fixed grid of start times;
- that a dropped write never produces a later frame.

// File: rtl/uart9_tx.sv
module uart9_tx #(
  parameter int DATA_W   = 8,
  parameter int SLICES   = 16,
  parameter int DIV_FAST = 2,
  parameter int DIV_SLOW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              fast_rate,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ninth_bit,
  input  logic              clr_done,
  output logic              txd,
  output logic              done_flag
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int BIT_W   = $clog2(FRAME_W + 1);
  localparam int SL_W    = $clog2(SLICES);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int PRE_W   = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [PRE_W-1:0] FAST_LAST = PRE_W'(DIV_FAST - 1);
  localparam logic [PRE_W-1:0] SLOW_LAST = PRE_W'(DIV_SLOW - 1);
  localparam logic [SL_W-1:0]  SL_LAST   = SL_W'(SLICES - 1);
  localparam logic [BIT_W-1:0] STOP_IDX  = BIT_W'(FRAME_W - 1);

  logic [PRE_W-1:0]   pre_cnt;
  logic [SL_W-1:0]    slice;
  logic [FRAME_W-1:0] shreg;
  logic [BIT_W-1:0]   bit_no;
  logic               pending, active;

  wire [PRE_W-1:0] pre_last = fast_rate ? FAST_LAST : SLOW_LAST;
  wire tick   = osc_en && (pre_cnt >= pre_last);
  wire roll   = tick && (slice == SL_LAST);
  wire busy   = pending | active;
  wire accept = wr_en & ~busy;
  wire last   = active && (bit_no == STOP_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      slice   <= '0;
    end else begin
      if (osc_en) pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick)   slice   <= slice + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      bit_no  <= '0;
      pending <= 1'b0;
      active  <= 1'b0;
      txd     <= 1'b1;
    end else if (accept) begin
      shreg   <= {1'b1, ninth_bit, wr_data};
      pending <= 1'b1;
    end else if (roll) begin
      if (pending) begin
        pending <= 1'b0;
        active  <= 1'b1;
        bit_no  <= '0;
        txd     <= 1'b0;
      end else if (active) begin
        txd    <= shreg[0];
        shreg  <= {1'b1, shreg[FRAME_W-1:1]};
        bit_no <= bit_no + 1'b1;
        if (last) active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            done_flag <= 1'b0;
    else if (roll && last) done_flag <= 1'b1;
    else if (clr_done)     done_flag <= 1'b0;
  end
endmodule

// File: rtl/uart9_tx_chk.sv
module uart9_tx_chk #(
  parameter int FW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          roll,
  input logic          busy,
  input logic          wr_en,
  input logic          clr_done,
  input logic          txd,
  input logic          done_flag,
  input logic [FW-1:0] shreg
);
  // R4
  txd_on_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !roll |=> $stable(txd));

  // R5
  done_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> txd);

  // R6
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_done) |=> done_flag);

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !roll) |=> !done_flag);

  // R7
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !roll) |=> $stable(shreg));
endmodule

bind uart9_tx uart9_tx_chk #(.FW(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .roll(roll), .busy(busy), .wr_en(wr_en),
  .clr_done(clr_done), .txd(txd), .done_flag(done_flag), .shreg(shreg)
);

// File: tb/test_uart9_tx.sv
module test_uart9_tx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b1;
  logic       fast_rate = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       ninth_bit = 1'b0;
  logic       clr_done = 1'b0;
  logic       txd, done_flag;
  logic       gap = 1'b0;

  int tests = 0, fails = 0;
  int cyc = 0;
  int last_start = 0;

  uart9_tx i_uart9_tx (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .fast_rate(fast_rate),
    .wr_en(wr_en), .wr_data(wr_data), .ninth_bit(ninth_bit),
    .clr_done(clr_done), .txd(txd), .done_flag(done_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) osc_en <= gap ? ~osc_en : 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d, input logic nb);
    @(negedge clk);
    wr_data = d; ninth_bit = nb; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = ~d; ninth_bit = ~nb;
  endtask

  task automatic clear_done();
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk(done_flag == 1'b0, "R6 clear", done_flag, 0);
  endtask

  // One frame with full bit-level check; optional mid-frame write
  task automatic t_frame(input logic [7:0] d, input logic nb, input logic fast,
                         input logic gapped, input logic intrude);
    int bl, c0, wc, n;
    logic [10:0] exp;
    fast_rate = fast; gap = gapped;
    bl = (fast ? 32 : 64) * (gapped ? 2 : 1);
    exp = {1'b1, nb, d, 1'b0};
    do_write(d, nb);
    wc = cyc - 1;
    n = 0;
    while (txd !== 1'b0 && n < bl + 4) begin @(negedge clk); n++; end
    c0 = cyc;
    last_start = c0;
    chk((c0 - wc) >= 1 && (c0 - wc) <= bl, "R4 start delay", c0 - wc, bl);
    for (int k = 0; k < 11; k++) begin
      if (k == 10) begin
        wait_to(c0 + 10*bl - 1);
        chk(done_flag == 1'b0, "R5 done early", done_flag, 0);
        @(negedge clk);
        chk(done_flag == 1'b1 && txd == 1'b1, "R5 done with stop", done_flag, 1);
      end
      wait_to(c0 + k*bl + bl/2);
      chk(txd == exp[k], (k == 0) ? "R2 start bit" : (k == 10) ? "R2 stop bit" : "R2 data bit",
          txd, exp[k]);
      if (k == 4 && intrude) do_write(~d, ~nb);
    end
    wait_to(c0 + 11*bl - 1);
    chk(txd == 1'b1, "R3 stop length", txd, 1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(done_flag == 1'b0, "R1 done", done_flag, 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    chk(txd == 1'b1, "R8 idle", txd, 1);
  endtask

  task automatic t_basic();
    t_frame(8'hA5, 1'b1, 1'b1, 1'b0, 1'b0);
    clear_done();
    t_frame(8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
    clear_done();
  endtask

  task automatic t_gapped();
    t_frame(8'h81, 1'b1, 1'b1, 1'b1, 1'b0);
    clear_done();
    gap = 1'b0;
  endtask

  task automatic t_grid();
    int s1;
    fast_rate = 1'b1;
    repeat (7) @(negedge clk);
    t_frame(8'h0F, 1'b0, 1'b1, 1'b0, 1'b0);
    s1 = last_start;
    clear_done();
    repeat (13) @(negedge clk);
    t_frame(8'hF0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(((last_start - s1) % 32) == 0, "R4 grid", (last_start - s1) % 32, 0);
    clear_done();
  endtask

  task automatic t_hold();
    int bad = 0;
    t_frame(8'h5A, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (80) begin @(negedge clk); if (done_flag !== 1'b1) bad++; end
    chk(bad == 0, "R6 hold", bad, 0);
    clear_done();
    repeat (5) @(negedge clk);
    chk(done_flag == 1'b0, "R6 stays clear", done_flag, 0);
  endtask

  task automatic t_ignore();
    int bad = 0;
    t_frame(8'hC3, 1'b1, 1'b1, 1'b0, 1'b1);
    clear_done();
    repeat (96) begin @(negedge clk); if (txd !== 1'b1) bad++; end
    chk(bad == 0, "R7 no extra frame", bad, 0);
    chk(done_flag == 1'b0, "R7 done stays clear", done_flag, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_gapped();
    t_grid();
    t_hold();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule